// File: doc/BRIEF.md
# Speculative Quarter-Rate Four-Level Decision-Feedback Equalizer

This block is a purely digital decision-feedback equalizer for a link that carries four-level pulse-amplitude symbols. Every clock it accepts four parallel 6-bit converter codes that stand for four consecutive symbol times. For each of them it returns a 2-bit symbol decision. Interference from the two preceding symbols is removed by subtracting two programmable tap weights, each multiplied by the level of the matching earlier decision.

The feedback loop is never closed through arithmetic. For every lane the block first computes all sixteen candidate values, one for each possible pair of earlier symbols, and slices each of them against three programmable thresholds. A register stage then holds these sliced candidates. In the next cycle a chain of multiplexers picks one decision per lane. The chain starts from the two decisions stored from the previous valid cycle and passes each lane's pick on to the lanes after it. The three thresholds and the two taps are written through a small select-and-data write port.

Top module: `pam4_spec_dfe`

## Requirements
- R1: For each symbol the equalized value is sample − tap1·L(d[n−1]) − tap2·L(d[n−2]). The level map L is code 00→−3, 01→−1, 10→+1, 11→+3. Samples and taps are 6-bit two's complement values, and the arithmetic does not overflow for any input.
- R2: An equalized value c slices to code 3 when c ≥ thr_hi, otherwise to 2 when c ≥ thr_mid, otherwise to 1 when c ≥ thr_lo, otherwise to 0. All comparisons are signed.
- R3: Lane i takes its sample from in_samples[6i+5:6i] and puts its decision on out_syms[2i+1:2i]. Lane 0 is the earliest symbol of the cycle and lane 3 the latest.
- R4: Lane 0 uses the lane-3 and lane-2 decisions of the previous valid cycle as d[n−1] and d[n−2]. Lanes 1 to 3 use the decisions of the earlier lanes of the same cycle.
- R5: out_valid is high exactly when in_valid was high two rising edges earlier. Its decisions belong to those samples, so the latency is fixed at 2 cycles.
- R6: A rising edge with rst_n low does the following: it sets both stored prior decisions to code 01, clears out_valid and out_syms, sets both taps to 0, and sets the thresholds to thr_lo −8, thr_mid 0 and thr_hi +8.
- R7: A rising edge with cfg_wr high writes cfg_data into the register picked by cfg_sel. The select codes are 0 tap1, 1 tap2, 2 thr_lo, 3 thr_mid and 4 thr_hi. A tap takes the low 6 bits of cfg_data, and a threshold takes all 8 bits as a signed value. Select codes 5 to 7 change nothing.
- R8: A cycle with in_valid low produces no valid output. It leaves out_syms and the stored prior decisions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter of the symbol rate |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_samples holds four new samples |
| in_samples | input | 24 | Four 6-bit signed samples, lane 0 in the low bits |
| cfg_wr | input | 1 | Write strobe for the settings |
| cfg_sel | input | 3 | Register select for a write |
| cfg_data | input | 8 | Write data |
| out_valid | output | 1 | out_syms holds four new decisions |
| out_syms | output | 8 | Four 2-bit decisions, lane 0 in the low bits |

## Verification
The first pattern is a directed sample set with zero taps. It places values exactly on, and one code below, each threshold, plus the extreme codes +31 and −32, so it separates a correct slicer from one that uses strict comparisons or unsigned comparisons. The second pattern is a pseudo-random seven-bit sequence mapped to four-level symbols and sent through an integer channel with two post-cursors. It contains idle gaps, which show whether lane ordering, the chaining within a cycle and the carrying of history across cycles and gaps are all correct. Its first cycle after reset depends on the −1 history. The third pattern rewrites a threshold and also writes to unused select codes, which tells a working write decoder apart from a missing one or one that aliases.

// File: rtl/pam4_dfe_pkg.sv
// Shared types and helpers for the speculative four-level equalizer.
// Assumes: symbol codes are 2 bits, and code order follows level order.
package pam4_dfe_pkg;

    localparam int NCAND = 16;   // candidate pairs of prior symbols (4 x 4)

    typedef enum logic [2:0] {
        SEL_TAP1    = 3'd0,
        SEL_TAP2    = 3'd1,
        SEL_THR_LO  = 3'd2,
        SEL_THR_MID = 3'd3,
        SEL_THR_HI  = 3'd4
    } cfg_sel_e;

    // Signed level of a symbol code: 00 -3, 01 -1, 10 +1, 11 +3.
    function automatic logic signed [2:0] sym_level(input logic [1:0] code);
        case (code)
            2'b00:   return -3'sd3;
            2'b01:   return -3'sd1;
            2'b10:   return 3'sd1;
            default: return 3'sd3;
        endcase
    endfunction

endpackage

// File: rtl/pam4_dfe_cfg.sv
// Settings register file: two tap weights and three slicer thresholds.
// Assumes: one write per cycle; unused select codes are dropped.
module pam4_dfe_cfg
    import pam4_dfe_pkg::*;
#(
    parameter int TW         = 6,
    parameter int CW         = 8,
    parameter int THR_LO_RST = -8,
    parameter int THR_MD_RST = 0,
    parameter int THR_HI_RST = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [2:0]           cfg_sel,
    input  logic [CW-1:0]        cfg_data,
    output logic signed [TW-1:0] tap1,
    output logic signed [TW-1:0] tap2,
    output logic signed [CW-1:0] thr_lo,
    output logic signed [CW-1:0] thr_mid,
    output logic signed [CW-1:0] thr_hi
);

    // Reset to defaults, then load the selected register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap1    <= '0;
            tap2    <= '0;
            thr_lo  <= CW'(THR_LO_RST);
            thr_mid <= CW'(THR_MD_RST);
            thr_hi  <= CW'(THR_HI_RST);
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_TAP1:    tap1    <= cfg_data[TW-1:0];
                SEL_TAP2:    tap2    <= cfg_data[TW-1:0];
                SEL_THR_LO:  thr_lo  <= cfg_data;
                SEL_THR_MID: thr_mid <= cfg_data;
                SEL_THR_HI:  thr_hi  <= cfg_data;
                default:     ;
            endcase
        end
    end

    AST_TAP1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'(SEL_TAP1)) |=> (tap1 == $past(cfg_data[TW-1:0]))); // R7

    AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel > 3'(SEL_THR_HI)) |=>
        ($stable(tap1) && $stable(tap2) && $stable(thr_lo) && $stable(thr_mid) && $stable(thr_hi))); // R7

endmodule

// File: rtl/pam4_dfe_cand.sv
// One lane of speculation: forms all 16 equalized candidates for the
// possible (previous, second previous) symbol pairs and slices each one.
// Assumes: SW+TW+3 bits hold every candidate and every sign-extended threshold.
module pam4_dfe_cand
    import pam4_dfe_pkg::*;
#(
    parameter int SW = 6,
    parameter int TW = 6,
    parameter int CW = 8
) (
    input  logic signed [SW-1:0]       sample,
    input  logic signed [TW-1:0]       tap1,
    input  logic signed [TW-1:0]       tap2,
    input  logic signed [CW-1:0]       thr_lo,
    input  logic signed [CW-1:0]       thr_mid,
    input  logic signed [CW-1:0]       thr_hi,
    output logic [NCAND-1:0][1:0]      dec
);

    localparam int AW = SW + TW + 3;

    logic signed [AW-1:0] smp_w, t1_w, t2_w, lo_w, md_w, hi_w;

    // Sign-extend every operand to the common arithmetic width.
    always_comb begin
        smp_w = AW'(sample);
        t1_w  = AW'(tap1);
        t2_w  = AW'(tap2);
        lo_w  = AW'(thr_lo);
        md_w  = AW'(thr_mid);
        hi_w  = AW'(thr_hi);
    end

    for (genvar p1 = 0; p1 < 4; p1++) begin : g_p1
        for (genvar p2 = 0; p2 < 4; p2++) begin : g_p2
            logic signed [AW-1:0] cand;
            assign cand = smp_w
                        - t1_w * AW'(sym_level(2'(p1)))
                        - t2_w * AW'(sym_level(2'(p2)));
            assign dec[p1*4 + p2] = (cand >= hi_w) ? 2'd3 :
                                    (cand >= md_w) ? 2'd2 :
                                    (cand >= lo_w) ? 2'd1 : 2'd0;
        end
    end

endmodule

// File: rtl/pam4_dfe_select.sv
// Selection chain: lane 0 picks with the stored history, and each later lane
// picks with the decisions just made by the lanes before it. Registers the
// outputs and updates the history from the last two lanes.
// Assumes: LANES >= 2; candidate index = {prev code, second-prev code}.
module pam4_dfe_select
    import pam4_dfe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              spec_vld,
    input  logic [LANES-1:0][NCAND-1:0][1:0]  spec,
    output logic                              out_valid,
    output logic [2*LANES-1:0]                out_syms
);

    logic [1:0]         hist1, hist2;   // latest and second-latest decision
    logic [2*LANES-1:0] lane_dec;

    for (genvar i = 0; i < LANES; i++) begin : g_ln
        logic [1:0] prev1, prev2, dec;
        if (i == 0) begin : g_first
            assign prev1 = hist1;
            assign prev2 = hist2;
        end else if (i == 1) begin : g_second
            assign prev1 = g_ln[0].dec;
            assign prev2 = hist1;
        end else begin : g_rest
            assign prev1 = g_ln[i-1].dec;
            assign prev2 = g_ln[i-2].dec;
        end
        assign dec = spec[i][{prev1, prev2}];
        assign lane_dec[2*i +: 2] = dec;
    end

    // Register decisions and carry the last two into the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_syms  <= '0;
            hist1     <= 2'b01;
            hist2     <= 2'b01;
        end else begin
            out_valid <= spec_vld;
            if (spec_vld) begin
                out_syms <= lane_dec;
                hist1    <= lane_dec[2*(LANES-1) +: 2];
                hist2    <= lane_dec[2*(LANES-2) +: 2];
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && hist1 == 2'b01 && hist2 == 2'b01)); // R6

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        spec_vld |=> out_valid); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_vld |=> (!out_valid && $stable(out_syms) && $stable(hist1) && $stable(hist2))); // R8

endmodule

// File: rtl/pam4_spec_dfe.sv
// Top: quarter-rate speculative two-tap equalizer for four-level symbols.
// Stage 1 slices all candidates per lane and registers them; stage 2 runs
// the selection chain. Latency from in_valid to out_valid is 2 cycles.
// Assumes: lane 0 holds the earliest symbol of each parallel word.
module pam4_spec_dfe
    import pam4_dfe_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SW    = 6,
    parameter int TW    = 6,
    parameter int CW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*SW-1:0]   in_samples,
    input  logic                  cfg_wr,
    input  logic [2:0]            cfg_sel,
    input  logic [CW-1:0]         cfg_data,
    output logic                  out_valid,
    output logic [2*LANES-1:0]    out_syms
);

    logic signed [TW-1:0]             tap1, tap2;
    logic signed [CW-1:0]             thr_lo, thr_mid, thr_hi;
    logic [LANES-1:0][NCAND-1:0][1:0] spec_d, spec_q;
    logic                             spec_vld;

    pam4_dfe_cfg #(.TW(TW), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .tap1(tap1), .tap2(tap2),
        .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pam4_dfe_cand #(.SW(SW), .TW(TW), .CW(CW)) u_cand (
            .sample(in_samples[i*SW +: SW]), .tap1(tap1), .tap2(tap2),
            .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
            .dec(spec_d[i])
        );
    end

    // Stage-1 register: hold the sliced candidates of the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_vld <= 1'b0;
            spec_q   <= '0;
        end else begin
            spec_vld <= in_valid;
            if (in_valid) spec_q <= spec_d;
        end
    end

    pam4_dfe_select #(.LANES(LANES)) u_sel (
        .clk(clk), .rst_n(rst_n), .spec_vld(spec_vld), .spec(spec_q),
        .out_valid(out_valid), .out_syms(out_syms)
    );

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!spec_vld && $stable(spec_q))); // R8

endmodule

// File: tb/sim_pam4_spec_dfe.sv
// Scoreboard bench: driver tasks queue the expected decision words, and a
// monitor pops and compares them whenever out_valid is high.
module sim_pam4_spec_dfe;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [23:0] in_samples = '0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic       out_valid;
    logic [7:0] out_syms;

    int         n_tests = 0;
    int         n_fail = 0;
    logic [7:0] exp_q[$];
    string      cur_req = "R2";
    logic [1:0] vp = '0;
    bit         done = 1'b0;
    logic [6:0] lfsr = 7'h7F;
    logic [7:0] popped;

    always #4 clk = ~clk;   // 125 MHz

    pam4_spec_dfe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_syms(out_syms)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lvl(input int code);
        return 2 * code - 3;
    endfunction

    function automatic logic [23:0] pk(input int a, input int b, input int c, input int d);
        return {6'(d), 6'(c), 6'(b), 6'(a)};
    endfunction

    function automatic logic [7:0] ek(input int a, input int b, input int c, input int d);
        return {2'(d), 2'(c), 2'(b), 2'(a)};
    endfunction

    // Valid pipeline expected from R5: two edges of delay.
    always @(posedge clk) begin
        if (!rst_n) vp <= '0;
        else        vp <= {vp[0], in_valid};
    end

    // Monitor: timing of out_valid and scoreboard comparison.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 out_valid timing", int'(out_valid), int'(vp[1]));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check({cur_req, " unexpected output"}, 1, 0);
                end else begin
                    popped = exp_q.pop_front();
                    check(cur_req, int'(out_syms), int'(popped));
                end
            end
        end
    end

    task automatic send(input logic [23:0] s, input logic [7:0] e);
        @(negedge clk);
        in_valid   = 1'b1;
        in_samples = s;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        idle(1);
    endtask

    task automatic cfg(input int sel, input int data);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_wr   = 1'b1;
        cfg_sel  = 3'(sel);
        cfg_data = 8'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Directed slicer words; valid whenever both taps are zero (R2, R3).
    task automatic slice_set(input string tag);
        cur_req = tag;
        send(pk(-9, -8, -1, 0), ek(0, 1, 1, 2));
        send(pk(7, 8, 31, -32), ek(2, 3, 3, 0));
        send(pk(-4, 5, -20, 9), ek(1, 2, 0, 3));
        idle(1);
        drain();
    endtask

    task automatic next_sym(output int s);
        logic b;
        s = 0;
        for (int k = 0; k < 2; k++) begin
            b    = lfsr[6] ^ lfsr[5];
            lfsr = {lfsr[5:0], b};
            s    = (s << 1) | int'(b);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int p1, p2, s, x;
        logic [23:0] w;
        logic [7:0]  e, last;

        repeat (3) @(negedge clk);
        check("R6 out_valid in reset", int'(out_valid), 0);
        check("R6 out_syms in reset", int'(out_syms), 0);
        rst_n = 1'b1;

        // Default thresholds -8/0/+8 and zero taps after reset.
        slice_set("R2 R3 R6 default slicing");

        // Second reset, then program taps 3 and -1.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        cfg(0, 3);
        cfg(1, -1);

        // PRBS stream through channel 4*s + 3*prev - prev2; history starts at code 01.
        cur_req = "R1 R4 R6 R8 feedback stream";
        p1 = 1;
        p2 = 1;
        for (int cyc = 0; cyc < 120; cyc++) begin
            if (cyc % 7 == 6) begin
                idle(1);
            end else begin
                for (int ln = 0; ln < 4; ln++) begin
                    next_sym(s);
                    x = 4 * lvl(s) + 3 * lvl(p1) - lvl(p2);
                    w[6*ln +: 6] = 6'(x);
                    e[2*ln +: 2] = 2'(s);
                    p2 = p1;
                    p1 = s;
                end
                send(w, e);
            end
        end
        idle(1);
        drain();

        // Idle cycles keep the last decisions on the output.
        last = out_syms;
        idle(4);
        check("R8 out_syms hold when idle", int'(out_syms), int'(last));
        check("R8 out_valid low when idle", int'(out_valid), 0);

        // Clear taps, write unused selects, slicing must be unchanged.
        cfg(0, 0);
        cfg(1, 0);
        cfg(5, 100);
        cfg(7, -128);
        slice_set("R7 unused select ignored");

        // Move the middle threshold to +4.
        cfg(3, 4);
        cur_req = "R7 threshold write";
        send(pk(3, 4, -8, -9), ek(1, 2, 1, 0));
        idle(1);
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule